// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides how a processor core enters an exception or interrupt handler. Each cycle it looks at a pending exception code, a hardware interrupt request together with the vector and priority level offered by an interrupt controller, and the core's current status word, program counter, vector base, stack register and delay-slot flags. When an entry is due, it captures the interrupted context, raises the privileged, blocked and bank-select bits of the status word, records the event code, and produces the handler address. All of this happens in one clock edge.

An exception always wins over an interrupt. While the status word's block bit is set, a pending exception is turned into a reset, except for one exempt code, and interrupts are refused unless a wake-from-halt flag is present. The handler address depends on the class of the code: reset-class codes go to a fixed reset address, translation-miss codes and all other exceptions go to two different offsets from the vector base, and interrupts go to a third. The saved PC is moved back by 2 when the interrupted instruction sat in a delay slot and forward by 2 for the trap code.

Top module: `entry_seq`

## Requirements
- R1: When an exception and an interrupt are pending together, the exception is taken; the interrupt event register keeps its value.
- R2: With status bit 28 (block) set, a pending exception code other than 0x1E0 is taken as code 0x000; code 0x1E0 is taken unchanged.
- R3: With status bit 28 set, an interrupt is ignored unless the wake input is 1; any entry taken with bit 28 set clears the wake output, an entry with bit 28 clear copies the wake input.
- R4: An interrupt is taken only when the controller's vector is valid and its level is strictly greater than status bits 7:4; otherwise no output register changes.
- R5: On entry the saved status takes the status input, the saved stack register takes the R15 input, and the new status is the old one with bits 28, 29 and 30 set.
- R6: When delay-slot flag bit 0 or bit 1 is set, the saved PC is the PC input minus 2 and the flag output becomes 0; flag bit 2 alone causes no correction and is copied.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15, set status bits 7:4 to 0xF and jump to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 jump to vector base + 0x400; every other exception code jumps to vector base + 0x100.
- R9: For the trap code 0x160, the saved PC is the PC input plus 2 (plus the R6 correction if both apply).
- R10: An exception writes its effective code to the exception event output; an accepted interrupt writes the vector to the interrupt event output and jumps to vector base + 0x600.
- R11: Outputs update on the clock edge that samples the request, with a one-cycle entry pulse; with no entry, all outputs hold.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | An exception code is pending |
| excCode | input | 12 | Pending exception code |
| irqReq | input | 1 | Hardware interrupt request |
| vecValid | input | 1 | Interrupt controller has a vector |
| vecCode | input | 12 | Interrupt vector from the controller |
| vecLevel | input | 4 | Priority level of that vector |
| srIn | input | 32 | Current status word |
| pcIn | input | 32 | Current program counter |
| vbrIn | input | 32 | Vector base |
| r15In | input | 32 | Current stack register |
| dlyIn | input | 3 | Delay-slot flags (bit0 slot, bit1 conditional slot, bit2 branch taken) |
| wakeIn | input | 1 | Wake-from-halt flag |
| entryTaken | output | 1 | One-cycle pulse: an entry was performed |
| pcOut | output | 32 | Handler address |
| srOut | output | 32 | New status word |
| ssrOut | output | 32 | Saved status word |
| spcOut | output | 32 | Saved program counter |
| sgrOut | output | 32 | Saved stack register |
| expEvtOut | output | 12 | Exception event code |
| intEvtOut | output | 12 | Interrupt event code |
| dlyOut | output | 3 | Delay-slot flags after entry |
| wakeOut | output | 1 | Wake flag after entry |

## Verification
A wrong priority or blocking decision shows one cycle after the request as a missing or spurious entry pulse, or as the wrong event register changing while the other stays put. A wrong class decode or an offset error shows on the same edge as a handler address off by a fixed amount, or as a status word with bit 15 or the mask field left untouched. Saved-PC adjustments appear as a saved PC two bytes away from the expected one, and any load without a request shows as an output that moves during an idle cycle.

// File: rtl/entry_seq_pkg.sv
package entry_seq_pkg;
  localparam int CODE_W    = 12;
  localparam int BIT_BLOCK = 28;
  localparam int BIT_BANK  = 29;
  localparam int BIT_PRIV  = 30;
  localparam int BIT_FPDIS = 15;
  localparam int MASK_LSB  = 4;
  localparam int MASK_W    = 4;

  localparam logic [CODE_W-1:0] CODE_RESET  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_MANUAL = 12'h020;
  localparam logic [CODE_W-1:0] CODE_MULTI  = 12'h140;
  localparam logic [CODE_W-1:0] CODE_MISSR  = 12'h040;
  localparam logic [CODE_W-1:0] CODE_MISSW  = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP   = 12'h160;
  localparam logic [CODE_W-1:0] CODE_EXEMPT = 12'h1E0;

  localparam logic [31:0] RESET_TARGET = 32'hA000_0000;
  localparam logic [31:0] OFS_GENERAL  = 32'h0000_0100;
  localparam logic [31:0] OFS_MISS     = 32'h0000_0400;
  localparam logic [31:0] OFS_IRQ      = 32'h0000_0600;

  typedef enum logic [1:0] {
    TGT_RESET, TGT_GENERAL, TGT_MISS, TGT_IRQ
  } target_e;

  typedef struct packed {
    logic              load;
    logic              isExp;
    logic              isIrq;
    target_e           target;
    logic              pcFwd;
    logic              pcBack;
    logic              clrWake;
    logic [CODE_W-1:0] code;
  } strobes_t;
endpackage

// File: rtl/entry_ctrl.sv
module entry_ctrl
  import entry_seq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [CODE_W-1:0] excCode,
  input  logic              irqReq,
  input  logic              vecValid,
  input  logic [LVL_W-1:0]  vecLevel,
  input  logic              srBlocked,
  input  logic [MASK_W-1:0] srMask,
  input  logic              inDelay,
  input  logic              wakeIn,
  output strobes_t          strb
);
  logic              forceReset;
  logic [CODE_W-1:0] effCode;
  logic              irqCand;
  logic              irqGate;
  logic              irqOk;
  target_e           excTarget;

  assign forceReset = srBlocked && (excCode != CODE_EXEMPT);
  assign effCode    = forceReset ? CODE_RESET : excCode;
  assign irqCand    = irqReq && !excValid;
  assign irqGate    = irqCand && (!srBlocked || wakeIn);
  assign irqOk      = irqGate && vecValid && (vecLevel > LVL_W'(srMask));

  always_comb begin
    unique case (effCode)
      CODE_RESET, CODE_MANUAL, CODE_MULTI: excTarget = TGT_RESET;
      CODE_MISSR, CODE_MISSW:              excTarget = TGT_MISS;
      default:                             excTarget = TGT_GENERAL;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.isExp   = excValid;
    strb.isIrq   = irqOk;
    strb.load    = excValid || irqOk;
    strb.target  = excValid ? excTarget : TGT_IRQ;
    strb.pcFwd   = excValid && (effCode == CODE_TRAP);
    strb.pcBack  = inDelay;
    strb.clrWake = srBlocked;
    strb.code    = effCode;
  end

  AST_EXC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !strb.isIrq); // R1
  AST_BLOCKED_EXC: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && srBlocked && excCode != CODE_EXEMPT) |-> (strb.target == TGT_RESET)); // R2
  AST_BLOCKED_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!excValid && srBlocked && !wakeIn) |-> !strb.load); // R3
  AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    strb.isIrq |-> (vecLevel > LVL_W'(srMask))); // R4
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.isExp, strb.isIrq})); // R1
endmodule

// File: rtl/entry_data.sv
module entry_data
  import entry_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int DLY_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [XLEN-1:0]   srIn,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   vbrIn,
  input  logic [XLEN-1:0]   r15In,
  input  logic [CODE_W-1:0] vecCode,
  input  logic [DLY_W-1:0]  dlyIn,
  input  logic              wakeIn,
  output logic              entryTaken,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   srOut,
  output logic [XLEN-1:0]   ssrOut,
  output logic [XLEN-1:0]   spcOut,
  output logic [XLEN-1:0]   sgrOut,
  output logic [CODE_W-1:0] expEvtOut,
  output logic [CODE_W-1:0] intEvtOut,
  output logic [DLY_W-1:0]  dlyOut,
  output logic              wakeOut
);
  localparam logic [XLEN-1:0] STEP = XLEN'(2);

  logic [XLEN-1:0] nextPc;
  logic [XLEN-1:0] nextSr;
  logic [XLEN-1:0] nextSpc;

  always_comb begin
    unique case (strb.target)
      TGT_RESET:   nextPc = XLEN'(RESET_TARGET);
      TGT_MISS:    nextPc = vbrIn + XLEN'(OFS_MISS);
      TGT_IRQ:     nextPc = vbrIn + XLEN'(OFS_IRQ);
      default:     nextPc = vbrIn + XLEN'(OFS_GENERAL);
    endcase
  end

  always_comb begin
    nextSr = srIn;
    nextSr[BIT_BLOCK] = 1'b1;
    nextSr[BIT_BANK]  = 1'b1;
    nextSr[BIT_PRIV]  = 1'b1;
    if (strb.target == TGT_RESET) begin
      nextSr[BIT_FPDIS] = 1'b0;
      nextSr[MASK_LSB +: MASK_W] = '1;
    end
  end

  always_comb begin
    nextSpc = pcIn;
    if (strb.pcBack) nextSpc = nextSpc - STEP;
    if (strb.pcFwd)  nextSpc = nextSpc + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryTaken <= 1'b0;
      pcOut      <= '0;
      srOut      <= '0;
      ssrOut     <= '0;
      spcOut     <= '0;
      sgrOut     <= '0;
      expEvtOut  <= '0;
      intEvtOut  <= '0;
      dlyOut     <= '0;
      wakeOut    <= 1'b0;
    end else begin
      entryTaken <= strb.load;
      if (strb.load) begin
        pcOut   <= nextPc;
        srOut   <= nextSr;
        ssrOut  <= srIn;
        spcOut  <= nextSpc;
        sgrOut  <= r15In;
        dlyOut  <= strb.pcBack ? '0 : dlyIn;
        wakeOut <= strb.clrWake ? 1'b0 : wakeIn;
        if (strb.isExp) expEvtOut <= strb.code;
        if (strb.isIrq) intEvtOut <= vecCode;
      end
    end
  end

  AST_SAVE_CTX: assert property (@(posedge clk) disable iff (!rstN)
    entryTaken |-> (ssrOut == $past(srIn)) && (sgrOut == $past(r15In))); // R5
  AST_SR_BITS: assert property (@(posedge clk) disable iff (!rstN)
    entryTaken |-> (srOut[BIT_BLOCK] && srOut[BIT_BANK] && srOut[BIT_PRIV])); // R5
  AST_DLY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (entryTaken && $past(strb.pcBack)) |-> (dlyOut[1:0] == 2'b00)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !entryTaken |-> ($stable(pcOut) && $stable(ssrOut) && $stable(expEvtOut))); // R11
endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import entry_seq_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LVL_W = 4,
  parameter int DLY_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic [11:0]       excCode,
  input  logic              irqReq,
  input  logic              vecValid,
  input  logic [11:0]       vecCode,
  input  logic [LVL_W-1:0]  vecLevel,
  input  logic [XLEN-1:0]   srIn,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [XLEN-1:0]   vbrIn,
  input  logic [XLEN-1:0]   r15In,
  input  logic [DLY_W-1:0]  dlyIn,
  input  logic              wakeIn,
  output logic              entryTaken,
  output logic [XLEN-1:0]   pcOut,
  output logic [XLEN-1:0]   srOut,
  output logic [XLEN-1:0]   ssrOut,
  output logic [XLEN-1:0]   spcOut,
  output logic [XLEN-1:0]   sgrOut,
  output logic [11:0]       expEvtOut,
  output logic [11:0]       intEvtOut,
  output logic [DLY_W-1:0]  dlyOut,
  output logic              wakeOut
);
  strobes_t strb;
  logic     inDelay;

  assign inDelay = |dlyIn[1:0];

  entry_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .vecValid(vecValid), .vecLevel(vecLevel),
    .srBlocked(srIn[BIT_BLOCK]), .srMask(srIn[MASK_LSB +: MASK_W]),
    .inDelay(inDelay), .wakeIn(wakeIn),
    .strb(strb)
  );

  entry_data #(.XLEN(XLEN), .DLY_W(DLY_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .srIn(srIn), .pcIn(pcIn), .vbrIn(vbrIn), .r15In(r15In),
    .vecCode(vecCode), .dlyIn(dlyIn), .wakeIn(wakeIn),
    .entryTaken(entryTaken), .pcOut(pcOut), .srOut(srOut),
    .ssrOut(ssrOut), .spcOut(spcOut), .sgrOut(sgrOut),
    .expEvtOut(expEvtOut), .intEvtOut(intEvtOut),
    .dlyOut(dlyOut), .wakeOut(wakeOut)
  );
endmodule

// File: tb/entry_seq_bench.sv
`timescale 1ns/1ps
module entry_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        excValid, irqReq, vecValid, wakeIn;
  logic [11:0] excCode, vecCode;
  logic [3:0]  vecLevel;
  logic [31:0] srIn, pcIn, vbrIn, r15In;
  logic [2:0]  dlyIn;
  logic        entryTaken, wakeOut;
  logic [31:0] pcOut, srOut, ssrOut, spcOut, sgrOut;
  logic [11:0] expEvtOut, intEvtOut;
  logic [2:0]  dlyOut;

  entry_seq u_entry_seq (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excCode(excCode),
    .irqReq(irqReq), .vecValid(vecValid), .vecCode(vecCode), .vecLevel(vecLevel),
    .srIn(srIn), .pcIn(pcIn), .vbrIn(vbrIn), .r15In(r15In),
    .dlyIn(dlyIn), .wakeIn(wakeIn), .entryTaken(entryTaken),
    .pcOut(pcOut), .srOut(srOut), .ssrOut(ssrOut), .spcOut(spcOut),
    .sgrOut(sgrOut), .expEvtOut(expEvtOut), .intEvtOut(intEvtOut),
    .dlyOut(dlyOut), .wakeOut(wakeOut)
  );

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] PC0  = 32'h0C00_1000;
  localparam logic [31:0] VBR0 = 32'h8C00_0000;
  localparam logic [31:0] R150 = 32'h0000_7FF0;
  localparam logic [31:0] S0   = 32'h0000_8030; // FD=1, mask=3
  localparam logic [31:0] SB   = 32'h1000_8030; // blocked

  typedef struct packed {
    logic        exc;
    logic [11:0] code;
    logic        irq;
    logic        vv;
    logic [11:0] vec;
    logic [3:0]  lvl;
    logic [31:0] sr;
    logic [2:0]  dly;
    logic        wake;
    logic        take;
    logic [31:0] pc;
    logic [31:0] srx;
    logic [31:0] spc;
    logic        isIrq;
    logic [11:0] evt;
  } row_t;

  localparam int NROWS = 19;
  localparam row_t TBL [NROWS] = '{
    '{1'b1,12'h0E0,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h0E0},
    '{1'b1,12'h040,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'h8C00_0400,32'h7000_8030,32'h0C00_1000,1'b0,12'h040},
    '{1'b1,12'h060,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'h8C00_0400,32'h7000_8030,32'h0C00_1000,1'b0,12'h060},
    '{1'b1,12'h020,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,1'b0,12'h020},
    '{1'b1,12'h140,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,1'b0,12'h140},
    '{1'b1,12'h160,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1002,1'b0,12'h160},
    '{1'b1,12'h0A0,1'b1,1'b1,12'h320,4'd9,S0,3'b000,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h0A0},
    '{1'b1,12'h100,1'b0,1'b0,12'h000,4'd0,SB,3'b000,1'b0, 1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,1'b0,12'h000},
    '{1'b1,12'h1E0,1'b0,1'b0,12'h000,4'd0,SB,3'b000,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h1E0},
    '{1'b0,12'h000,1'b1,1'b1,12'h5A0,4'd4,S0,3'b000,1'b0, 1'b1,32'h8C00_0600,32'h7000_8030,32'h0C00_1000,1'b1,12'h5A0},
    '{1'b0,12'h000,1'b1,1'b1,12'h3C0,4'd3,S0,3'b000,1'b0, 1'b0,32'h0,32'h0,32'h0,1'b0,12'h0},
    '{1'b0,12'h000,1'b1,1'b0,12'h3C0,4'd9,S0,3'b000,1'b0, 1'b0,32'h0,32'h0,32'h0,1'b0,12'h0},
    '{1'b0,12'h000,1'b1,1'b1,12'h3C0,4'd9,SB,3'b000,1'b0, 1'b0,32'h0,32'h0,32'h0,1'b0,12'h0},
    '{1'b0,12'h000,1'b1,1'b1,12'h600,4'd9,SB,3'b000,1'b1, 1'b1,32'h8C00_0600,32'h7000_8030,32'h0C00_1000,1'b1,12'h600},
    '{1'b1,12'h0E0,1'b0,1'b0,12'h000,4'd0,S0,3'b001,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_0FFE,1'b0,12'h0E0},
    '{1'b1,12'h160,1'b0,1'b0,12'h000,4'd0,S0,3'b010,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h160},
    '{1'b1,12'h000,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b0, 1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,1'b0,12'h000},
    '{1'b1,12'h0E0,1'b0,1'b0,12'h000,4'd0,S0,3'b000,1'b1, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h0E0},
    '{1'b1,12'h0E0,1'b0,1'b0,12'h000,4'd0,S0,3'b100,1'b0, 1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,1'b0,12'h0E0}
  };

  logic [31:0] ePc, eSr, eSsr, eSpc, eSgr;
  logic [11:0] eExp, eInt;
  logic [2:0]  eDly;
  logic        eWake;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkAll(input logic expTaken);
    chk("R4 R3 R11 entryTaken", 32'(entryTaken), 32'(expTaken));
    chk("R7 R8 R10 pcOut", pcOut, ePc);
    chk("R5 R7 srOut", srOut, eSr);
    chk("R5 ssrOut", ssrOut, eSsr);
    chk("R6 R9 spcOut", spcOut, eSpc);
    chk("R5 sgrOut", sgrOut, eSgr);
    chk("R2 R10 expEvtOut", 32'(expEvtOut), 32'(eExp));
    chk("R1 R10 intEvtOut", 32'(intEvtOut), 32'(eInt));
    chk("R6 dlyOut", 32'(dlyOut), 32'(eDly));
    chk("R3 wakeOut", 32'(wakeOut), 32'(eWake));
  endtask

  task automatic idleInputs();
    excValid = 1'b0; irqReq = 1'b0; vecValid = 1'b0; wakeIn = 1'b0;
    excCode = '0; vecCode = '0; vecLevel = '0; dlyIn = '0;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    srIn = S0; pcIn = PC0; vbrIn = VBR0; r15In = R150;
    ePc = '0; eSr = '0; eSsr = '0; eSpc = '0; eSgr = '0;
    eExp = '0; eInt = '0; eDly = '0; eWake = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R12: reset state
    chkAll(1'b0);

    for (int i = 0; i < NROWS; i++) begin
      excValid = TBL[i].exc;  excCode = TBL[i].code;
      irqReq   = TBL[i].irq;  vecValid = TBL[i].vv;
      vecCode  = TBL[i].vec;  vecLevel = TBL[i].lvl;
      srIn     = TBL[i].sr;   dlyIn = TBL[i].dly;
      wakeIn   = TBL[i].wake;
      if (TBL[i].take) begin
        ePc = TBL[i].pc; eSr = TBL[i].srx; eSpc = TBL[i].spc;
        eSsr = TBL[i].sr; eSgr = R150;
        if (TBL[i].isIrq) eInt = TBL[i].evt;
        else              eExp = TBL[i].evt;
        eDly  = (|TBL[i].dly[1:0]) ? 3'b000 : TBL[i].dly;
        eWake = TBL[i].sr[28] ? 1'b0 : TBL[i].wake;
      end
      @(negedge clk);
      chkAll(TBL[i].take);
      // R11: idle cycle, pulse drops and everything holds
      idleInputs();
      @(negedge clk);
      chkAll(1'b0);
    end

    // R11: changing context inputs with no request moves nothing
    srIn = 32'h0000_0000; pcIn = 32'h1234_5678; r15In = 32'hDEAD_BEEF; vbrIn = 32'h0;
    @(negedge clk);
    @(negedge clk);
    chkAll(1'b0);

    // R12: reset in the middle clears state again
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    ePc = '0; eSr = '0; eSsr = '0; eSpc = '0; eSgr = '0;
    eExp = '0; eInt = '0; eDly = '0; eWake = 1'b0;
    chkAll(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule